// File: doc/BRIEF.md
# Power-Domain Bring-Up Sequencer

This block switches a chip's power domains on in a fixed order after power-on reset or after a wake from deep sleep. It has nine stages: a bandgap reference, a digital regulator, four SRAM banks, the radio power switch, the non-volatile memory power switch and the oscillator. Each stage raises its own enable and then waits a settle time set by a parameter. Power-reduction mask bits can deselect the four SRAM banks and the radio. A deselected stage keeps its enable low and passes at once. When the oscillator stage has finished, the block raises a reset-out signal so that the processor's normal wake-up can continue.

The block also decides whether the chain may be switched off when the processor sleeps. Shutdown is allowed only in the two deepest sleep modes, and only if the radio is masked off or is in its sleep state. A shutdown drops every enable and reset-out together. A later wake request runs the chain again from the reference stage, without the cold-start delay. A sleep request that arrives while the chain is still sequencing is remembered and acted on once the chain completes.

Top module: `pcs_chain_seq`

## Requirements
- R1: The enables rise in this order: reference (bit 0), regulator (bit 1), SRAM banks 0..3 (bits 2..5), radio (bit 6), non-volatile memory (bit 7), oscillator (bit 8). An enable that has risen stays high until shutdown or reset.
- R2: A stage that is not masked lasts its delay parameter plus one clock cycle. A delay of zero therefore lasts exactly one cycle. SRAM stages use SRAM_CYC, the radio and memory stages use PSW_CYC, and the reference, regulator and oscillator stages use REF_CYC, VREG_CYC and OSC_CYC.
- R3: After a synchronous reset is released, the block waits POR_CYC+1 cycles before the reference stage begins. This applies even when the reset arrives in the middle of a run.
- R4: A wake from the off state skips the power-on-reset delay. The reference enable rises on the clock edge that samples wake_req.
- R5: pr_mask bits 0..3 deselect SRAM banks 0..3 and bit 4 deselects the radio. A deselected stage keeps its enable low and lasts exactly one cycle.
- R6: rst_out rises only on the edge after the oscillator stage completes. At that point every stage that is not masked is enabled.
- R7: The block shuts down only if sleep_mode is 3'd2 (power-down) or 3'd3 (power-save), and pr_mask bit 4 or rf_sleep is high. Any other mode, or an active radio, keeps the chain on.
- R8: A permitted sleep request drops all enables and rst_out on the next clock edge.
- R9: wake_req has no effect unless the chain is off.
- R10: busy is high from reset through the last stage and low once the chain is complete or off.
- R11: A sleep_req seen while busy is held. It is evaluated on the first edge after completion, and dropped if shutdown is not permitted at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (cold start) |
| pr_mask | input | 5 | Deselect bits: [3:0] SRAM banks, [4] radio |
| rf_sleep | input | 1 | Radio is in its sleep state |
| sleep_req | input | 1 | Processor requests sleep |
| sleep_mode | input | 3 | Requested sleep mode (2 power-down, 3 power-save) |
| wake_req | input | 1 | Wake from deep sleep |
| dom_en | output | 9 | Per-stage domain enables |
| rst_out | output | 1 | Chain complete, processor may start |
| busy | output | 1 | Chain is sequencing |

## Verification
The assertions assume that pr_mask does not change while busy is high. A mask change in the middle of a run would leave an earlier stage's enable in a state that no longer matches its bit. The bench therefore changes the mask only while the chain is off or idle, and applies a new mask before the wake request that uses it. The shutdown-permission property looks at sleep_mode, rf_sleep and pr_mask one cycle before rst_out falls. The stimulus holds those inputs steady around each sleep request, so the sampled values are the ones the decision was made on.

// File: rtl/pcs_pkg.sv
// Shared constants and types for the power-chain sequencer.
// Assumes a fixed topology of four SRAM banks plus five single stages.
package pcs_pkg;
    localparam int NBANK = 4;
    localparam int NST   = NBANK + 5;
    localparam int IDX_W = $clog2(NST);

    localparam int ST_REF  = 0;
    localparam int ST_VREG = 1;
    localparam int ST_RF   = NBANK + 2;
    localparam int ST_NVM  = NBANK + 3;
    localparam int ST_OSC  = NBANK + 4;

    localparam logic [2:0] MODE_PWRDOWN = 3'd2;
    localparam logic [2:0] MODE_PWRSAVE = 3'd3;

    typedef enum logic [1:0] {
        PH_POR,
        PH_RUN,
        PH_DONE,
        PH_OFF
    } pcs_phase_t;
endpackage

// File: rtl/pcs_timer.sv
// Settle-time down-counter. It loads on request, otherwise it counts down
// to zero and holds there. Reset loads init_val (the power-on delay).
module pcs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] init_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Count the current stage's remaining cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= init_val;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pcs_sleep_gate.sv
// Shutdown permission. The chain may turn off only in the two deepest
// sleep modes, and only with the radio masked off or asleep.
// Purely combinational; the caller samples the result.
module pcs_sleep_gate
    import pcs_pkg::*;
(
    input  logic [2:0] sleep_mode,
    input  logic       rf_masked,
    input  logic       rf_sleep,
    output logic       allow
);
    logic deep_mode;

    // Decode which modes allow the chain to go off.
    always_comb begin
        deep_mode = (sleep_mode == MODE_PWRDOWN) || (sleep_mode == MODE_PWRSAVE);
        allow     = deep_mode && (rf_masked || rf_sleep);
    end
endmodule

// File: rtl/pcs_chain_seq.sv
// Power-domain bring-up sequencer (top). It walks nine stages in a fixed
// order, and each unmasked stage raises its enable and waits its settle
// time. It raises rst_out when the chain is complete, and turns the chain
// off on a permitted sleep request. Assumes pr_mask is stable while busy.
module pcs_chain_seq
    import pcs_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int POR_CYC  = 16,
    parameter int REF_CYC  = 8,
    parameter int VREG_CYC = 6,
    parameter int SRAM_CYC = 2,
    parameter int PSW_CYC  = 3,
    parameter int OSC_CYC  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NBANK:0] pr_mask,
    input  logic           rf_sleep,
    input  logic           sleep_req,
    input  logic [2:0]     sleep_mode,
    input  logic           wake_req,
    output logic [NST-1:0] dom_en,
    output logic           rst_out,
    output logic           busy
);
    pcs_phase_t       phase;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] nidx;
    logic [NST-1:0]   en_q;
    logic             pend;
    logic [NST-1:0]   skip;
    logic [CNT_W-1:0] dly [NST];
    logic             t_zero;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             allow;
    logic             stage_end;
    logic             last;
    logic             enter_first;

    // Per-stage delay and skip tables, built from the parameters.
    for (genvar i = 0; i < NST; i++) begin : g_stage
        if (i == ST_REF) begin : g_ref
            assign dly[i]  = CNT_W'(REF_CYC);
            assign skip[i] = 1'b0;
        end else if (i == ST_VREG) begin : g_vreg
            assign dly[i]  = CNT_W'(VREG_CYC);
            assign skip[i] = 1'b0;
        end else if (i < ST_RF) begin : g_bank
            assign dly[i]  = CNT_W'(SRAM_CYC);
            assign skip[i] = pr_mask[i-2];
        end else if (i == ST_RF) begin : g_rf
            assign dly[i]  = CNT_W'(PSW_CYC);
            assign skip[i] = pr_mask[NBANK];
        end else if (i == ST_NVM) begin : g_nvm
            assign dly[i]  = CNT_W'(PSW_CYC);
            assign skip[i] = 1'b0;
        end else begin : g_osc
            assign dly[i]  = CNT_W'(OSC_CYC);
            assign skip[i] = 1'b0;
        end
    end

    pcs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_val (CNT_W'(POR_CYC)),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_zero)
    );

    pcs_sleep_gate u_gate (
        .sleep_mode (sleep_mode),
        .rf_masked  (pr_mask[NBANK]),
        .rf_sleep   (rf_sleep),
        .allow      (allow)
    );

    // Stage-advance decode and timer reload selection.
    always_comb begin
        nidx        = idx + 1'b1;
        last        = (idx == IDX_W'(NST - 1));
        stage_end   = (phase == PH_RUN) && (t_zero || skip[idx]);
        enter_first = ((phase == PH_POR) && t_zero) ||
                      ((phase == PH_OFF) && wake_req);
        t_load      = enter_first || (stage_end && !last);
        t_val       = enter_first ? dly[0] : dly[nidx];
    end

    // Phase, stage index, enables and the held sleep request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_POR;
            idx   <= '0;
            en_q  <= '0;
            pend  <= 1'b0;
        end else begin
            case (phase)
                PH_POR: begin
                    if (sleep_req) pend <= 1'b1;
                    if (t_zero) begin
                        phase   <= PH_RUN;
                        idx     <= '0;
                        en_q[0] <= 1'b1;
                    end
                end
                PH_RUN: begin
                    if (sleep_req) pend <= 1'b1;
                    if (stage_end) begin
                        if (last) begin
                            phase <= PH_DONE;
                        end else begin
                            idx        <= nidx;
                            en_q[nidx] <= !skip[nidx];
                        end
                    end
                end
                PH_DONE: begin
                    if (sleep_req || pend) begin
                        pend <= 1'b0;
                        if (allow) begin
                            phase <= PH_OFF;
                            en_q  <= '0;
                        end
                    end
                end
                default: begin
                    pend <= 1'b0;
                    if (wake_req) begin
                        phase <= PH_RUN;
                        idx   <= '0;
                        en_q  <= NST'(1);
                    end
                end
            endcase
        end
    end

    assign dom_en  = en_q;
    assign rst_out = (phase == PH_DONE);
    assign busy    = (phase == PH_POR) || (phase == PH_RUN);
endmodule

// File: rtl/pcs_chain_chk.sv
// Port-level properties of the sequencer, bound into every instance.
// Assumes pr_mask is stable while busy is high.
module pcs_chain_chk
    import pcs_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [NBANK:0] pr_mask,
    input logic           rf_sleep,
    input logic [2:0]     sleep_mode,
    input logic           wake_req,
    input logic [NST-1:0] dom_en,
    input logic           rst_out,
    input logic           busy
);
    AST_ORDER_OSC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_en[ST_OSC]) |-> (dom_en[ST_REF] && dom_en[ST_VREG])); // R1
    AST_MASKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((dom_en[ST_RF:2] & pr_mask) == '0)); // R5
    AST_RSTOUT_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> (dom_en[ST_OSC] && dom_en[ST_REF])); // R6
    AST_OFF_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (($past(sleep_mode) == MODE_PWRDOWN || $past(sleep_mode) == MODE_PWRSAVE)
                            && ($past(pr_mask[NBANK]) || $past(rf_sleep)))); // R7
    AST_DROP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (dom_en == '0)); // R8
    AST_WAKE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rst_out && wake_req) |=> (busy && dom_en == NST'(1))); // R4
    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && rst_out)); // R10
endmodule

bind pcs_chain_seq pcs_chain_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pr_mask    (pr_mask),
    .rf_sleep   (rf_sleep),
    .sleep_mode (sleep_mode),
    .wake_req   (wake_req),
    .dom_en     (dom_en),
    .rst_out    (rst_out),
    .busy       (busy)
);

// File: tb/sim_pcs_chain_seq.sv
// Bench: a behavioural reference model compared on every clock, plus
// directed checks on stage timing, masking and sleep gating.
module sim_pcs_chain_seq;
    localparam int P_POR = 16, P_REF = 8, P_VREG = 6, P_SRAM = 2, P_PSW = 0, P_OSC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pr_mask = '0;
    logic       rf_sleep = 1'b0;
    logic       sleep_req = 1'b0;
    logic [2:0] sleep_mode = 3'd0;
    logic       wake_req = 1'b0;
    logic [8:0] dom_en;
    logic       rst_out;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pcs_chain_seq #(.POR_CYC(P_POR), .REF_CYC(P_REF), .VREG_CYC(P_VREG),
                    .SRAM_CYC(P_SRAM), .PSW_CYC(P_PSW), .OSC_CYC(P_OSC)) u0 (
        .clk(clk), .rst_n(rst_n), .pr_mask(pr_mask), .rf_sleep(rf_sleep),
        .sleep_req(sleep_req), .sleep_mode(sleep_mode), .wake_req(wake_req),
        .dom_en(dom_en), .rst_out(rst_out), .busy(busy));

    // Reference model: phase 0 por, 1 run, 2 done, 3 off.
    int m_ph, m_idx, m_cnt;
    bit m_pend, m_valid;
    logic [8:0] m_en;

    function automatic int stage_delay(int i);
        if (i == 0) return P_REF;
        if (i == 1) return P_VREG;
        if (i >= 2 && i <= 5) return P_SRAM;
        if (i == 6 || i == 7) return P_PSW;
        return P_OSC;
    endfunction

    function automatic bit stage_masked(int i);
        if (i >= 2 && i <= 5) return pr_mask[i-2];
        if (i == 6) return pr_mask[4];
        return 1'b0;
    endfunction

    function automatic bit may_sleep();
        return (sleep_mode == 3'd2 || sleep_mode == 3'd3) && (pr_mask[4] || rf_sleep);
    endfunction

    // Expected edges from a stage start to the completed chain.
    function automatic int chain_len();
        int s = 0;
        for (int i = 0; i < 9; i++) s += stage_masked(i) ? 1 : stage_delay(i) + 1;
        return s;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_cnt = P_POR; m_idx = 0; m_en = '0; m_pend = 0; m_valid = 1;
        end else if (m_valid) begin
            case (m_ph)
                0: begin
                    if (sleep_req) m_pend = 1;
                    if (m_cnt == 0) begin m_ph = 1; m_idx = 0; m_cnt = stage_delay(0); m_en[0] = 1'b1; end
                    else m_cnt--;
                end
                1: begin
                    if (sleep_req) m_pend = 1;
                    if (m_cnt == 0 || stage_masked(m_idx)) begin
                        if (m_idx == 8) m_ph = 2;
                        else begin
                            m_idx++; m_cnt = stage_delay(m_idx); m_en[m_idx] = !stage_masked(m_idx);
                        end
                    end else m_cnt--;
                end
                2: if (sleep_req || m_pend) begin
                    m_pend = 0;
                    if (may_sleep()) begin m_ph = 3; m_en = '0; end
                end
                default: begin
                    m_pend = 0;
                    if (wake_req) begin m_ph = 1; m_idx = 0; m_cnt = stage_delay(0); m_en = 9'h001; end
                end
            endcase
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (m_valid && !finished) begin
            chk(dom_en, m_en, "R1 model dom_en");
            chk(rst_out, m_ph == 2, "R6 model rst_out");
            chk(busy, m_ph < 2, "R10 model busy");
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Count edges until rst_out is seen high; the first edge drops wake_req.
    task automatic run_to_done(output int n);
        n = 0;
        while (!rst_out && n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            wake_req = 1'b0;
            sleep_req = 1'b0;
        end
    endtask

    initial begin
        int n;
        int exp_n;
        repeat (3) @(negedge clk);
        chk(dom_en, 0, "R3 reset dom_en");
        chk(rst_out, 0, "R3 reset rst_out");
        chk(busy, 1, "R10 reset busy");

        // Cold start with nothing masked.
        rst_n = 1'b1;
        repeat (P_POR) step();
        chk(dom_en, 0, "R3 ref still off during por delay");
        step();
        chk(dom_en, 1, "R3 ref on after por delay");
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
        exp_n = P_POR + 1 + chain_len();
        run_to_done(n);
        chk(n, exp_n, "R2 R3 cold chain length");
        chk(dom_en, 9'h1FF, "R6 all enables at done");

        // Wake ignored while complete.
        wake_req = 1'b1; step(); wake_req = 1'b0;
        chk(rst_out, 1, "R9 wake ignored rst_out");
        chk(busy, 0, "R9 wake ignored busy");

        // Shutdown not permitted: shallow mode, radio asleep.
        sleep_mode = 3'd0; rf_sleep = 1'b1; sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk(rst_out, 1, "R7 shallow mode keeps chain");
        // Not permitted: power-down with active radio.
        sleep_mode = 3'd2; rf_sleep = 1'b0; sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk(rst_out, 1, "R7 active radio keeps chain");
        chk(dom_en, 9'h1FF, "R7 enables kept");
        // Permitted: power-save with radio asleep.
        sleep_mode = 3'd3; rf_sleep = 1'b1; sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk(rst_out, 0, "R8 rst_out dropped");
        chk(dom_en, 0, "R8 enables dropped");

        // Wake with banks 0, 2 and the radio masked.
        pr_mask = 5'b10101; rf_sleep = 1'b0;
        wake_req = 1'b1;
        @(posedge clk); @(negedge clk); wake_req = 1'b0;
        chk(dom_en, 1, "R4 ref on the edge after wake");
        exp_n = chain_len();
        run_to_done(n);
        chk(n + 1, exp_n + 1, "R4 R5 wake chain length");
        chk(dom_en, 9'h1AB, "R5 masked enables low");

        // Radio masked permits power-down even with rf_sleep low.
        sleep_mode = 3'd2; sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk(rst_out, 0, "R7 masked radio permits off");

        // Held request while busy, then permitted.
        pr_mask = 5'b00000; rf_sleep = 1'b1; sleep_mode = 3'd2;
        wake_req = 1'b1; step(); wake_req = 1'b0;
        step(); sleep_req = 1'b1; step(); sleep_req = 1'b0;
        run_to_done(n);
        chk(rst_out, 1, "R11 done before held request");
        step();
        chk(rst_out, 0, "R11 held request acted");

        // Held request while busy, not permitted at completion.
        wake_req = 1'b1; step(); wake_req = 1'b0;
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        sleep_mode = 3'd0;
        run_to_done(n);
        repeat (3) step();
        chk(rst_out, 1, "R11 held request dropped");
        chk(busy, 0, "R10 idle after done");

        finish_run();
    end
endmodule